// File: doc/BRIEF.md
# Execution Port Dispatcher

This block takes one decoded micro-op per cycle from a valid/ready stream and sends its parts to a set of six execution ports. Ports 0, 1 and 5 are arithmetic. Port 2 reads memory. Ports 3 and 4 take the address and the data of a store. Each micro-op carries a six-bit mask of the ports it may use. An arithmetic part goes to the first of its allowed arithmetic ports that is free. Memory parts go only to their own ports. The issue strobes are combinational. They are asserted in the same cycle that the handshake completes.

A single entry may hold a fused pair, for example an arithmetic operation together with a load. Such an entry is issued only when every resource it needs is free in that cycle. The block keeps two occupancy counters. The fused-domain counter adds one for each accepted entry. The unfused counter adds one for each port strobe. Fusion is present in a cycle exactly when the unfused step is larger than the fused step. A macro-fused compare-and-branch therefore adds one to each counter. Both counters saturate, and a synchronous reset clears them.

Top module: `uopPortDispatch`

## Requirements
- R1: While `rst` is high at a clock edge, both counters become 0. With `inValid` low, `issue` is all zero.
- R2: Mask bits 0, 1 and 5 select arithmetic ports. Exactly one arithmetic port issues: the lowest-numbered allowed port whose `portBusy` bit is 0.
- R3: If the mask selects arithmetic ports and none of them is free, `inReady` is low and nothing issues.
- R4: Mask bit 2 selects the load port. The load part issues on port 2 only, and only while `portBusy[2]` is 0.
- R5: Mask bit 3 or bit 4 marks a store. A store issues on ports 3 and 4 together. It waits, with `inReady` low, unless both ports are free in the same cycle.
- R6: When a mask names several parts (arithmetic, load, store), all of them issue in one cycle. If any part lacks a free port, `inReady` is low and no part issues.
- R7: Each accepted entry with a non-zero mask adds 1 to `fusedCount` at the next clock edge.
- R8: Each accepted entry adds the number of asserted `issue` bits to `unfusedCount` at the next clock edge.
- R9: Both counters hold at 65535 instead of wrapping.
- R10: An all-zero mask keeps `inReady` high. It issues nothing and leaves both counters unchanged.
- R11: With `inValid` low, nothing issues and the counters keep their values, whatever the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Micro-op present |
| inReady | output | 1 | All needed ports free; entry accepted when valid |
| inMask | input | 6 | Allowed/needed port set, bit i = port i |
| portBusy | input | 6 | Port i cannot take work this cycle |
| issue | output | 6 | Issue strobe per port |
| fusedCount | output | 16 | Saturating fused-domain entry count |
| unfusedCount | output | 16 | Saturating per-port micro-op count |

## Verification
Single arithmetic masks are driven against busy patterns that rule out the lower ports one at a time. This shows whether the choice is the lowest free port or a fixed one. Load, store and combined masks are driven with exactly one needed port busy. These separate an all-or-nothing issue from a partial issue. A long run of the widest mask drives the unfused counter to its ceiling well before the fused counter. This shows that each counter saturates on its own and that the counter steps differ when fusion is present. Random masks and busy vectors cover the remaining combinations against the behavioural model.

// File: rtl/dispatchPkg.sv
package dispatchPkg;
  localparam int NUM_PORTS = 6;
  localparam int P_ALU0  = 0;
  localparam int P_ALU1  = 1;
  localparam int P_LOAD  = 2;
  localparam int P_STADR = 3;
  localparam int P_STDAT = 4;
  localparam int P_ALU5  = 5;
  localparam int INC_W   = $clog2(NUM_PORTS + 1);

  typedef logic [NUM_PORTS-1:0] portVec;

  localparam portVec ARITH_SET = portVec'((1 << P_ALU0) | (1 << P_ALU1) | (1 << P_ALU5));
  localparam portVec STORE_SET = portVec'((1 << P_STADR) | (1 << P_STDAT));

  typedef struct packed {
    logic             accept;
    logic [INC_W-1:0] unfusedInc;
  } cntStrobe;
endpackage

// File: rtl/dispatchCtrl.sv
module dispatchCtrl
  import dispatchPkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  input  portVec   inMask,
  input  portVec   portBusy,
  output logic     inReady,
  output portVec   issue,
  output cntStrobe strobe
);
  portVec freeVec;
  portVec arithCand;
  portVec arithPick;
  portVec plan;
  logic   needArith, needLoad, needStore;
  logic   arithOk, loadOk, storeOk, accept;
  logic [INC_W-1:0] popCount;

  assign freeVec   = ~portBusy;
  assign needArith = |(inMask & ARITH_SET);
  assign needLoad  = inMask[P_LOAD];
  assign needStore = |(inMask & STORE_SET);

  // lowest set bit of the free allowed arithmetic ports
  assign arithCand = inMask & ARITH_SET & freeVec;
  assign arithPick = arithCand & (~arithCand + portVec'(1));

  assign arithOk = !needArith || (|arithCand);
  assign loadOk  = !needLoad  || freeVec[P_LOAD];
  assign storeOk = !needStore || (freeVec[P_STADR] && freeVec[P_STDAT]);

  assign inReady = arithOk && loadOk && storeOk;
  assign accept  = inValid && inReady && (|inMask);

  always_comb begin
    plan = arithPick;
    if (needLoad) plan[P_LOAD] = 1'b1;
    if (needStore) begin
      plan[P_STADR] = 1'b1;
      plan[P_STDAT] = 1'b1;
    end
  end

  assign issue = accept ? plan : '0;

  always_comb begin
    popCount = '0;
    for (int i = 0; i < NUM_PORTS; i++) popCount = popCount + INC_W'(issue[i]);
  end

  assign strobe.accept     = accept;
  assign strobe.unfusedInc = popCount;

  a_r3_no_busy_issue: assert property (@(posedge clk) disable iff (rst)
    (issue & portBusy) == '0);
  a_r2_one_arith: assert property (@(posedge clk) disable iff (rst)
    $onehot0(issue & ARITH_SET));
  a_r5_store_pair: assert property (@(posedge clk) disable iff (rst)
    issue[P_STADR] == issue[P_STDAT]);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !inValid |-> (issue == '0));
  a_r6_subset: assert property (@(posedge clk) disable iff (rst)
    (issue & ~(inMask | STORE_SET)) == '0);
endmodule

// File: rtl/dispatchCounters.sv
module dispatchCounters
  import dispatchPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cntStrobe         strobe,
  output logic [CNT_W-1:0] fusedCount,
  output logic [CNT_W-1:0] unfusedCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W:0]   unfusedSum;
  logic [CNT_W-1:0] unfusedNext;
  logic [CNT_W-1:0] fusedNext;

  assign unfusedSum  = {1'b0, unfusedCount} + {{(CNT_W + 1 - INC_W){1'b0}}, strobe.unfusedInc};
  assign unfusedNext = unfusedSum[CNT_W] ? CNT_MAX : unfusedSum[CNT_W-1:0];
  assign fusedNext   = (fusedCount == CNT_MAX) ? CNT_MAX : fusedCount + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      fusedCount   <= '0;
      unfusedCount <= '0;
    end else if (strobe.accept) begin
      fusedCount   <= fusedNext;
      unfusedCount <= unfusedNext;
    end
  end

  a_r9_fused_hold: assert property (@(posedge clk) disable iff (rst)
    (fusedCount == CNT_MAX) |=> (fusedCount == CNT_MAX));
  a_r9_unfused_hold: assert property (@(posedge clk) disable iff (rst)
    (unfusedCount == CNT_MAX) |=> (unfusedCount == CNT_MAX));
  a_r7_no_accept_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.accept |=> $stable(fusedCount) && $stable(unfusedCount));
  a_r8_unfused_ge: assert property (@(posedge clk) disable iff (rst)
    (unfusedCount != CNT_MAX && fusedCount != CNT_MAX) |-> (unfusedCount >= fusedCount));
endmodule

// File: rtl/uopPortDispatch.sv
module uopPortDispatch
  import dispatchPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output logic             inReady,
  input  logic [5:0]       inMask,
  input  logic [5:0]       portBusy,
  output logic [5:0]       issue,
  output logic [CNT_W-1:0] fusedCount,
  output logic [CNT_W-1:0] unfusedCount
);
  cntStrobe strobe;

  dispatchCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inMask   (inMask),
    .portBusy (portBusy),
    .inReady  (inReady),
    .issue    (issue),
    .strobe   (strobe)
  );

  dispatchCounters #(.CNT_W(CNT_W)) uCnt (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .fusedCount   (fusedCount),
    .unfusedCount (unfusedCount)
  );
endmodule

// File: tb/tb_uopPortDispatch.sv
module tb_uopPortDispatch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [5:0]  inMask = '0;
  logic [5:0]  portBusy = '0;
  logic [5:0]  issue;
  logic [15:0] fusedCount, unfusedCount;

  int nChecks = 0;
  int nFails  = 0;
  int expFused = 0;
  int expUnfused = 0;

  always #10 clk = ~clk;

  uopPortDispatch dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inMask(inMask), .portBusy(portBusy), .issue(issue),
    .fusedCount(fusedCount), .unfusedCount(unfusedCount)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [5:0] m, input logic [5:0] b,
                      input string tag, input string cntTag);
    logic [5:0] eIss;
    logic       eRdy, aOk, found;
    int         order [3];
    int         pop;
    @(negedge clk);
    inValid = v; inMask = m; portBusy = b;
    #5;
    order = '{0, 1, 5};
    eIss = '0; found = 1'b0;
    foreach (order[k]) if (!found && m[order[k]] && !b[order[k]]) begin
      eIss[order[k]] = 1'b1; found = 1'b1;
    end
    aOk  = !(m[0] || m[1] || m[5]) || found;
    eRdy = aOk && (!m[2] || !b[2]) && (!(m[3] || m[4]) || (!b[3] && !b[4]));
    if (m[2]) eIss[2] = 1'b1;
    if (m[3] || m[4]) begin eIss[3] = 1'b1; eIss[4] = 1'b1; end
    if (!(v && eRdy && m != 0)) eIss = '0;
    check({tag, " ready"}, int'(inReady), int'(eRdy));
    check({tag, " issue"}, int'(issue), int'(eIss));
    check({cntTag, " fused"}, int'(fusedCount), expFused);
    check({cntTag, " unfused"}, int'(unfusedCount), expUnfused);
    pop = $countones(eIss);
    if (eIss != 0) begin
      expFused   = (expFused + 1 > 65535) ? 65535 : expFused + 1;
      expUnfused = (expUnfused + pop > 65535) ? 65535 : expUnfused + pop;
    end
  endtask

  initial begin
    #(20 * 190000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 fused reset", int'(fusedCount), 0);
    check("R1 unfused reset", int'(unfusedCount), 0);
    check("R1 issue idle", int'(issue), 0);
    rst = 1'b0;
    // R2 lowest free arithmetic port
    step(1, 6'b100011, 6'b000000, "R2 all free", "R7R8");
    step(1, 6'b100011, 6'b000001, "R2 p0 busy", "R7R8");
    step(1, 6'b100011, 6'b000011, "R2 p0p1 busy", "R7R8");
    step(1, 6'b100010, 6'b000000, "R2 p1p5", "R7R8");
    step(1, 6'b100001, 6'b000001, "R2 p0p5", "R7R8");
    // R3 stall
    step(1, 6'b000011, 6'b000011, "R3 stall", "R7R8");
    step(1, 6'b100000, 6'b100000, "R3 stall p5", "R7R8");
    // R4 load
    step(1, 6'b000100, 6'b000000, "R4 load", "R7R8");
    step(1, 6'b000100, 6'b000100, "R4 load busy", "R7R8");
    // R5 store
    step(1, 6'b011000, 6'b000000, "R5 store", "R7R8");
    step(1, 6'b001000, 6'b000000, "R5 store addr only", "R7R8");
    step(1, 6'b011000, 6'b010000, "R5 store data busy", "R7R8");
    step(1, 6'b010000, 6'b001000, "R5 store addr busy", "R7R8");
    // R6 fused parts
    step(1, 6'b000101, 6'b000000, "R6 alu+load", "R7R8");
    step(1, 6'b000101, 6'b000100, "R6 load part busy", "R7R8");
    step(1, 6'b111111, 6'b000001, "R6 all parts", "R7R8");
    step(1, 6'b011011, 6'b000011, "R6 alu part busy", "R7R8");
    // R10 empty mask
    step(1, 6'b000000, 6'b111111, "R10 empty", "R10");
    step(1, 6'b000000, 6'b000000, "R10 empty", "R10");
    // R11 idle
    step(0, 6'b111111, 6'b000000, "R11 idle", "R11");
    step(0, 6'b000001, 6'b000000, "R11 idle", "R11");
    // random mix
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 3) != 0), 6'($urandom), 6'($urandom & $urandom),
           "R2R6 random", "R7R8");
    // R9 saturation
    for (int i = 0; i < 66000; i++)
      step(1, 6'b011101, 6'b000000, "R9 sat", "R9");
    step(1, 6'b000001, 6'b000000, "R9 after sat", "R9");
    step(1, 6'b000001, 6'b000000, "R9 after sat", "R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule